// File: doc/BRIEF.md
# Serial Code-Phase Search Engine

This block performs the coarse acquisition step of a direct-sequence spread-spectrum receiver. A maximal-length linear feedback shift register produces a local copy of the spreading code. Each incoming baseband sample, given as one hard-decision bit, is multiplied by the local copy as a bipolar value. The products are summed over one full code period. Samples arrive at two per chip, so the local copy can be moved by either a whole chip or half a chip.

At the end of each period the sum is latched and compared with a signed threshold supplied at run time. If the sum falls short, the local copy is pushed ahead by the selected step and the next period is tested. If the sum reaches the threshold, the code phase is frozen and the lock flag rises for a downstream tracking stage. A synchronous clear input restarts the search from offset zero.

Raising or lowering the threshold trades missed detections against false alarms. For a whole-chip search the usual threshold is N−1 in the block's raw units, and for a half-chip search it is (3N−1)/2. N is the code length and each period spans 2N samples.

Top module: `pn_acquire`

## Requirements
- R1: Chip bit 0 stands for +1 and bit 1 for −1. A sample equal to the replica chip adds +1 to the running sum, and a differing sample adds −1.
- R2: The replica follows a[n+5] = a[n] xor a[n+2], starting from five ones (a[0..4] = 1). Replica position p selects chip a[p/2], so each chip lasts two samples and the code period is 2N = 62 samples.
- R3: After 2N valid samples, the full sum appears on corr_hold in the cycle after the last sample. The next period then sums from zero, and corr_hold does not change at any other time.
- R4: A period whose sum is at or above the signed threshold sets locked in the cycle after its last sample. A sum equal to the threshold counts as a hit.
- R5: A period that falls short while unlocked moves the replica position ahead by 2 samples when half_step is 0, or by 1 sample when half_step is 1. phase_off grows by the same amount, modulo 2N.
- R6: Once locked, phase_off stays frozen and locked stays high until clear. corr_hold keeps updating every period.
- R7: One cycle after clr is high, phase_off, locked and corr_hold are zero. The sample count and the replica both restart at position 0.
- R8: After reset, phase_off, locked and corr_hold read zero.
- R9: A cycle with smp_valid low leaves the sum, the replica, phase_off, locked and corr_hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of the search |
| smp_valid | input | 1 | Sample strobe (two strobes per chip) |
| smp_chip | input | 1 | Received hard-decision chip bit |
| half_step | input | 1 | 1 selects half-chip slips, 0 selects whole-chip slips |
| threshold | input | 7 | Signed decision threshold in raw sum units |
| corr_hold | output | 7 | Signed correlation sum of the last completed period |
| locked | output | 1 | Acquisition achieved, phase frozen |
| phase_off | output | 6 | Replica slip in half-chip units, modulo 2N |

## Verification
corr_hold, locked and phase_off all change on the clock edge that takes the last valid sample of a period. The bench leaves one idle cycle after each period and compares all three at the following falling edge. The expected values come from its own code table and its own model of the slip offset. The effects of clr are due one edge after the strobe, and the bench checks them at the next falling edge. Idle cycles are checked by verifying that nothing has moved before the next sample is driven.

// File: rtl/pn_acq_pkg.sv
package pn_acq_pkg;

  typedef enum logic {
    SLIP_CHIP = 1'b0,
    SLIP_HALF = 1'b1
  } slip_mode_e;

  // slip size in samples (two samples per chip)
  function automatic logic [1:0] slip_samples(input slip_mode_e mode);
    return (mode == SLIP_HALF) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/pn_replica.sv
module pn_replica #(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 5'b00101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv_en,
  input  logic [1:0] adv_n,
  output logic       rep_chip
);

  localparam logic [W-1:0] SEED = {W{1'b1}};

  logic [W-1:0] st_q, st_d;
  logic         h_q, h_d;

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {^(s & TAPS), s[W-1:1]};
  endfunction

  always_comb begin
    st_d = st_q;
    h_d  = h_q;
    if (clr) begin
      st_d = SEED;
      h_d  = 1'b0;
    end else if (adv_en) begin
      for (int i = 0; i < 3; i++) begin
        if (2'(i) < adv_n) begin
          if (h_d) st_d = lfsr_next(st_d);
          h_d = ~h_d;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
      h_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      h_q  <= h_d;
    end
  end

  assign rep_chip = st_q[0];

endmodule

// File: rtl/pn_integrator.sv
module pn_integrator #(
  parameter int PER   = 62,
  parameter int CNT_W = 6,
  parameter int ACC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    smp_valid,
  input  logic                    prod_pos,
  output logic                    period_end,
  output logic signed [ACC_W-1:0] sum_now,
  output logic signed [ACC_W-1:0] corr_hold
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PER - 1);

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] hold_q, hold_d;

  assign sum_now    = prod_pos ? acc_q + ACC_W'(1) : acc_q - ACC_W'(1);
  assign period_end = smp_valid && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    hold_d = hold_q;
    if (clr) begin
      cnt_d  = '0;
      acc_d  = '0;
      hold_d = '0;
    end else if (smp_valid) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        acc_d  = '0;
        hold_d = sum_now;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        acc_d = sum_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      hold_q <= hold_d;
    end
  end

  assign corr_hold = hold_q;

endmodule

// File: rtl/pn_search.sv
module pn_search
  import pn_acq_pkg::*;
#(
  parameter int PER   = 62,
  parameter int OFF_W = 6,
  parameter int ACC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    smp_valid,
  input  logic                    period_end,
  input  logic signed [ACC_W-1:0] sum_now,
  input  logic signed [ACC_W-1:0] threshold,
  input  logic                    half_step,
  output logic                    locked,
  output logic [OFF_W-1:0]        phase_off,
  output logic [1:0]              adv_n
);

  logic             lock_q, lock_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [1:0]       step;
  logic             miss;
  logic [OFF_W:0]   off_sum;

  assign step    = slip_samples(slip_mode_e'(half_step));
  assign miss    = period_end && !lock_q && (sum_now < threshold);
  assign off_sum = {1'b0, off_q} + (OFF_W + 1)'(step);

  always_comb begin
    if (!smp_valid || clr) adv_n = 2'd0;
    else if (miss)         adv_n = 2'd1 + step;
    else                   adv_n = 2'd1;
  end

  always_comb begin
    off_d  = off_q;
    lock_d = lock_q;
    if (clr) begin
      off_d  = '0;
      lock_d = 1'b0;
    end else if (miss) begin
      if (off_sum >= (OFF_W + 1)'(PER)) off_d = OFF_W'(off_sum - (OFF_W + 1)'(PER));
      else                              off_d = off_sum[OFF_W-1:0];
    end else if (period_end && !lock_q) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      off_q  <= off_d;
      lock_q <= lock_d;
    end
  end

  assign locked    = lock_q;
  assign phase_off = off_q;

endmodule

// File: rtl/pn_acquire.sv
module pn_acquire #(
  parameter int           LFSR_W = 5,
  parameter logic [LFSR_W-1:0] TAPS = 5'b00101,
  localparam int          N      = (1 << LFSR_W) - 1,
  localparam int          PER    = 2 * N,
  localparam int          CNT_W  = $clog2(PER),
  localparam int          OFF_W  = $clog2(PER),
  localparam int          ACC_W  = $clog2(PER + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    smp_valid,
  input  logic                    smp_chip,
  input  logic                    half_step,
  input  logic signed [ACC_W-1:0] threshold,
  output logic signed [ACC_W-1:0] corr_hold,
  output logic                    locked,
  output logic [OFF_W-1:0]        phase_off
);

  logic                    rep_chip;
  logic [1:0]              adv_n;
  logic                    period_end;
  logic signed [ACC_W-1:0] sum_now;

  pn_replica #(.W(LFSR_W), .TAPS(TAPS)) u_replica (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv_en   (smp_valid),
    .adv_n    (adv_n),
    .rep_chip (rep_chip)
  );

  pn_integrator #(.PER(PER), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .smp_valid  (smp_valid),
    .prod_pos   (smp_chip ~^ rep_chip),
    .period_end (period_end),
    .sum_now    (sum_now),
    .corr_hold  (corr_hold)
  );

  pn_search #(.PER(PER), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .smp_valid  (smp_valid),
    .period_end (period_end),
    .sum_now    (sum_now),
    .threshold  (threshold),
    .half_step  (half_step),
    .locked     (locked),
    .phase_off  (phase_off),
    .adv_n      (adv_n)
  );

endmodule

// File: rtl/pn_acq_checker.sv
module pn_acq_checker #(
  parameter int PER   = 62,
  parameter int OFF_W = 6,
  parameter int ACC_W = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    smp_valid,
  input logic                    period_end,
  input logic signed [ACC_W-1:0] threshold,
  input logic signed [ACC_W-1:0] corr_hold,
  input logic                    locked,
  input logic [OFF_W-1:0]        phase_off
);

  assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_off < OFF_W'(PER));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !clr |=> locked);

  assert_phase_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !clr |=> $stable(phase_off));

  assert_hold_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end && !clr |=> $stable(corr_hold));

  assert_lock_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> corr_hold >= $past(threshold));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_off == '0) && !locked && (corr_hold == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !clr |=> $stable(phase_off) && $stable(locked) && $stable(corr_hold));

endmodule

bind pn_acquire pn_acq_checker #(.PER(PER), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .smp_valid  (smp_valid),
  .period_end (period_end),
  .threshold  (threshold),
  .corr_hold  (corr_hold),
  .locked     (locked),
  .phase_off  (phase_off)
);

// File: tb/test_pn_acquire.sv
module test_pn_acquire;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 31;
  localparam int PER        = 2 * N;

  logic              clk, rst_n, clr, smp_valid, smp_chip, half_step;
  logic signed [6:0] threshold;
  logic signed [6:0] corr_hold;
  logic              locked;
  logic [5:0]        phase_off;

  int n_checks, n_fail;
  bit seq [0:N-1];

  pn_acquire i_pn_acquire (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
    .smp_chip(smp_chip), .half_step(half_step), .threshold(threshold),
    .corr_hold(corr_hold), .locked(locked), .phase_off(phase_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit chip_at(input int x);
    int m = ((x % PER) + PER) % PER;
    return seq[m / 2];
  endfunction

  function automatic int corr(input int d);
    int s = 0;
    for (int u = 0; u < PER; u++) s += (chip_at(u + d) == chip_at(u)) ? 1 : -1;
    return s;
  endfunction

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // drives nper periods of received code delayed by d samples, checks after each
  task automatic run_search(input int d, input bit half, input int thr, input int nper,
                            input bit gaps, input string req);
    int off_m = 0;
    bit lock_m = 0;
    int t = 0;
    int exp_hold;
    do_clear();
    half_step = half;
    threshold = 7'(thr);
    for (int p = 0; p < nper; p++) begin
      for (int s = 0; s < PER; s++) begin
        if (gaps && (s % 7 == 3)) begin
          @(negedge clk);
          smp_valid = 1'b0;
        end
        @(negedge clk);
        smp_valid = 1'b1;
        smp_chip  = chip_at(t + d);
        t++;
      end
      @(negedge clk);
      smp_valid = 1'b0;
      exp_hold = corr(d - off_m);
      if (!lock_m) begin
        if (exp_hold >= thr) lock_m = 1'b1;
        else off_m = (off_m + (half ? 1 : 2)) % PER;
      end
      chk({req, " R1 R2 R3"}, $sformatf("corr_hold period %0d", p), int'(corr_hold), exp_hold);
      chk({req, " R4"}, $sformatf("locked period %0d", p), int'(locked), int'(lock_m));
      chk({req, " R5 R6"}, $sformatf("phase_off period %0d", p), int'(phase_off), off_m);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr = 1'b0; smp_valid = 1'b0; smp_chip = 1'b0;
    half_step = 1'b0; threshold = 7'sd30;
    repeat (3) @(negedge clk);
    chk("R8", "locked in reset", int'(locked), 0);
    chk("R8", "phase_off in reset", int'(phase_off), 0);
    chk("R8", "corr_hold in reset", int'(corr_hold), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_whole();   // lock at offset 6 after 3 misses, then frozen (R5, R6)
    run_search(6, 1'b0, 30, 6, 1'b0, "R5 whole");
  endtask

  task automatic t_half();    // odd lag reachable only by half-chip slips (R5)
    run_search(5, 1'b1, 46, 8, 1'b0, "R5 half");
  endtask

  task automatic t_equal();   // sum exactly at threshold locks; one above misses (R4)
    run_search(1, 1'b1, 30, 2, 1'b0, "R4 equal");
    run_search(1, 1'b1, 31, 3, 1'b0, "R4 above");
  endtask

  task automatic t_wrap();    // unreachable threshold, offset wraps modulo 2N (R5)
    run_search(0, 1'b0, 63, 33, 1'b0, "R5 wrap");
  endtask

  task automatic t_gaps();    // idle strobes inside periods change nothing (R9)
    run_search(4, 1'b0, 30, 4, 1'b1, "R9 gaps");
  endtask

  task automatic t_clear_idle();
    int h0, o0;
    run_search(8, 1'b0, 30, 5, 1'b0, "R7 pre");
    h0 = int'(corr_hold); o0 = int'(phase_off);
    repeat (5) @(negedge clk);
    chk("R9", "corr_hold while idle", int'(corr_hold), h0);
    chk("R9", "phase_off while idle", int'(phase_off), o0);
    chk("R9", "locked while idle", int'(locked), 1);
    do_clear();
    chk("R7", "locked after clear", int'(locked), 0);
    chk("R7", "phase_off after clear", int'(phase_off), 0);
    chk("R7", "corr_hold after clear", int'(corr_hold), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    for (int i = 0; i < 5; i++) seq[i] = 1'b1;
    for (int i = 5; i < N; i++) seq[i] = seq[i-5] ^ seq[i-3];
    t_reset();
    t_whole();
    t_half();
    t_equal();
    t_wrap();
    t_gaps();
    t_clear_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule